// File: doc/BRIEF.md
# Segmented Instruction Prefetch Unit

This block runs ahead of instruction execution in a 16-bit processor with segmented addressing. It holds a code segment value and a 16-bit fetch offset. From these it forms a 20-bit physical byte address: the segment is moved up by four bit positions and the offset is added. It then reads code bytes one at a time over a simple memory bus. The bus has an address, an address-latch strobe, a read strobe and a memory/IO select.

Fetched bytes are placed in a six-entry first-in-first-out queue, which the execution side drains through a pop input. The unit keeps fetching while the queue has room and stops when it is full. After each fetch it advances its own offset, so the offset always points at the next byte to be read.

A branch or jump is signalled on the flush input, which carries a new segment and offset. A flush discards every queued byte and abandons any fetch that is under way. Fetching then restarts from the new location.

Top module: `pfq_prefetch_unit`

## Requirements
- R1: While a fetch is in progress, `bus_addr` equals ((segment << 4) + offset) modulo 2^20, and it holds that value unchanged through the read cycles of that fetch.
- R2: During reset and just after it, the queue is empty and `bus_ale` and `bus_rd` are low. The segment resets to 0xFFFF and the offset to 0x0000, so the first fetch after reset presents address 0xFFFF0.
- R3: Each fetch takes exactly three cycles. In the first, `bus_ale`=1, `bus_rd`=0 and `bus_mio`=1. In the second and third, `bus_ale`=0 and `bus_rd`=1. `bus_data` is captured into the queue at the clock edge that ends the third cycle.
- R4: Each completed fetch raises the offset by one, and the offset wraps from 0xFFFF to 0x0000. Bytes enter the queue in the order of their fetch addresses.
- R5: The queue holds at most six bytes. No fetch starts (no `bus_ale` pulse) while six bytes are queued and no pop is requested.
- R6: `q_byte` presents the oldest queued byte. `q_valid` is 1 exactly when `q_count` is non-zero. Each accepted pop removes the head byte.
- R7: A pop requested while the queue is empty has no effect: `q_count` stays 0, and the next byte fetched becomes the head.
- R8: When a pop and a captured byte fall in the same cycle, `q_count` is unchanged afterwards. The head advances to the next older byte, and the new byte goes to the tail.
- R9: A flush loads the new segment and offset, empties the queue by the next cycle and aborts any fetch in progress without queuing its byte. The next fetch uses the new address.
- R10: `bus_mio` is 1 (memory) whenever `bus_ale` or `bus_rd` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Redirect: load new segment/offset and empty the queue |
| flush_seg | input | 16 | New code segment value loaded on flush |
| flush_off | input | 16 | New fetch offset loaded on flush |
| pop | input | 1 | Execution side takes the head byte |
| q_byte | output | 8 | Oldest queued byte |
| q_valid | output | 1 | Queue holds at least one byte |
| q_count | output | 3 | Number of queued bytes (0 to 6) |
| bus_addr | output | 20 | Physical fetch address |
| bus_ale | output | 1 | Address-latch strobe, first cycle of a fetch |
| bus_rd | output | 1 | Read strobe, second and third cycles of a fetch |
| bus_mio | output | 1 | 1 selects memory, 0 IO/idle |
| bus_data | input | 8 | Byte returned by memory |

## Verification
Two operations can land on the same clock edge. One is the execution side popping the head byte. The other is the bus sequencer writing a freshly captured byte to the tail. To force this, the bench tracks the read strobe and raises pop exactly in the third cycle of a fetch. It then checks three things: the count is unchanged, the head is now the second-oldest expected byte, and the next fetch starts at once. A second case puts a flush on the cycle where the read strobe is high. This checks that the byte from the abandoned fetch never reaches the queue.

// File: rtl/pfq_pkg.sv
package pfq_pkg;
   typedef enum logic [1:0] {
      FS_IDLE = 2'd0,
      FS_ADDR = 2'd1,
      FS_RD1  = 2'd2,
      FS_RD2  = 2'd3
   } fetch_state_t;

   localparam int unsigned PFQ_DEF_DEPTH = 6;
   localparam int unsigned PFQ_DEF_SEG_W = 16;
   localparam int unsigned PFQ_DEF_OFF_W = 16;
   localparam int unsigned PFQ_DEF_SHIFT = 4;
   localparam int unsigned PFQ_DEF_DW    = 8;
endpackage

// File: rtl/pfq_addr_gen.sv
module pfq_addr_gen #(
   parameter int unsigned SEG_W = 16,
   parameter int unsigned OFF_W = 16,
   parameter int unsigned SHIFT = 4,
   parameter int unsigned PA_W  = SEG_W + SHIFT,
   parameter bit          SPLIT = 1'b1
) (
   input  logic [SEG_W-1:0] seg,
   input  logic [OFF_W-1:0] off,
   output logic [PA_W-1:0]  phys
);
   localparam int unsigned UP_W = PA_W - SHIFT;

   initial begin
      AST_PA_WIDTH: assert (PA_W == SEG_W + SHIFT);  // R1
      AST_OFF_WIDE: assert (OFF_W > SHIFT);          // R1
   end

   generate
      if (SPLIT) begin : g_split
         // low bits pass straight through; only the upper part needs a carry chain
         logic [UP_W-1:0] upper;
         assign upper = UP_W'(seg) + UP_W'(off >> SHIFT);
         assign phys  = {upper, off[SHIFT-1:0]};
      end else begin : g_full
         assign phys = PA_W'({seg, {SHIFT{1'b0}}}) + PA_W'(off);
      end
   endgenerate
endmodule

// File: rtl/pfq_byte_fifo.sv
module pfq_byte_fifo #(
   parameter int unsigned DEPTH = 6,
   parameter int unsigned DW    = 8,
   localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             push,
   input  logic [DW-1:0]    push_data,
   input  logic             pop_req,
   output logic [DW-1:0]    head,
   output logic             valid,
   output logic [CNT_W-1:0] count,
   output logic             free_after
);
   initial begin
      AST_DEPTH_POS: assert (DEPTH >= 1);  // R5
   end

   logic [PTR_W-1:0] wr_ptr, rd_ptr;
   logic [DW-1:0]    store [DEPTH];
   logic             push_eff, pop_eff;
   logic [CNT_W:0]   count_nx;

   function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
      return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
   endfunction

   assign pop_eff  = pop_req && (count != '0) && !clr;
   assign push_eff = push && !clr;
   assign count_nx = (CNT_W+1)'(count) + (CNT_W+1)'(push_eff) - (CNT_W+1)'(pop_eff);
   assign free_after = count_nx < (CNT_W+1)'(DEPTH);

   generate
      for (genvar i = 0; i < DEPTH; i++) begin : g_slot
         always_ff @(posedge clk) begin
            if (push_eff && wr_ptr == PTR_W'(i))
               store[i] <= push_data;
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push_eff) wr_ptr <= ptr_inc(wr_ptr);
         if (pop_eff)  rd_ptr <= ptr_inc(rd_ptr);
         count <= CNT_W'(count_nx);
      end
   end

   assign head  = store[rd_ptr];
   assign valid = (count != '0);

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> (count < CNT_W'(DEPTH)));                              // R5
   AST_SAME_CYCLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (push_eff && pop_eff) |=> (count == $past(count)));             // R8
   AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (count == '0));                                         // R9
   AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_req && count == '0 && !push) |=> (count == '0));           // R7
endmodule

// File: rtl/pfq_bus_seq.sv
module pfq_bus_seq
   import pfq_pkg::*;
#(
   parameter int unsigned        SEG_W     = 16,
   parameter int unsigned        OFF_W     = 16,
   parameter logic [SEG_W-1:0]   RESET_SEG = '1,
   parameter logic [OFF_W-1:0]   RESET_OFF = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic [SEG_W-1:0] new_seg,
   input  logic [OFF_W-1:0] new_off,
   input  logic             room,
   output logic [SEG_W-1:0] seg_q,
   output logic [OFF_W-1:0] off_q,
   output logic             push,
   output logic             ale,
   output logic             rd,
   output logic             mio
);
   fetch_state_t state, state_nx;

   always_comb begin
      state_nx = state;
      unique case (state)
         FS_IDLE: if (room) state_nx = FS_ADDR;
         FS_ADDR: state_nx = FS_RD1;
         FS_RD1:  state_nx = FS_RD2;
         FS_RD2:  state_nx = room ? FS_ADDR : FS_IDLE;
         default: state_nx = FS_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= FS_IDLE;
         seg_q <= RESET_SEG;
         off_q <= RESET_OFF;
      end else if (flush) begin
         state <= FS_IDLE;
         seg_q <= new_seg;
         off_q <= new_off;
      end else begin
         state <= state_nx;
         if (state == FS_RD2) off_q <= off_q + 1'b1;
      end
   end

   assign push = (state == FS_RD2) && !flush;
   assign ale  = (state == FS_ADDR);
   assign rd   = (state == FS_RD1) || (state == FS_RD2);
   assign mio  = (state != FS_IDLE);

   AST_ALE_THEN_RD: assert property (@(posedge clk) disable iff (!rst_n)
      (ale && !flush) |=> (rd && !ale));                       // R3
   AST_IP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      push |=> (off_q == OFF_W'($past(off_q) + 1'b1)));        // R4
   AST_FLUSH_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (off_q == $past(new_off) && !rd && !ale));     // R9
endmodule

// File: rtl/pfq_prefetch_unit.sv
module pfq_prefetch_unit
   import pfq_pkg::*;
#(
   parameter int unsigned      DEPTH       = PFQ_DEF_DEPTH,
   parameter int unsigned      SEG_W       = PFQ_DEF_SEG_W,
   parameter int unsigned      OFF_W       = PFQ_DEF_OFF_W,
   parameter int unsigned      ADDR_SHIFT  = PFQ_DEF_SHIFT,
   parameter int unsigned      DW          = PFQ_DEF_DW,
   parameter bit               SPLIT_ADDER = 1'b1,
   parameter logic [SEG_W-1:0] RESET_SEG   = '1,
   parameter logic [OFF_W-1:0] RESET_OFF   = '0,
   localparam int unsigned     PA_W        = SEG_W + ADDR_SHIFT,
   localparam int unsigned     CNT_W       = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic [SEG_W-1:0] flush_seg,
   input  logic [OFF_W-1:0] flush_off,
   input  logic             pop,
   output logic [DW-1:0]    q_byte,
   output logic             q_valid,
   output logic [CNT_W-1:0] q_count,
   output logic [PA_W-1:0]  bus_addr,
   output logic             bus_ale,
   output logic             bus_rd,
   output logic             bus_mio,
   input  logic [DW-1:0]    bus_data
);
   logic [SEG_W-1:0] seg_q;
   logic [OFF_W-1:0] off_q;
   logic             push, room;

   pfq_bus_seq #(
      .SEG_W(SEG_W), .OFF_W(OFF_W),
      .RESET_SEG(RESET_SEG), .RESET_OFF(RESET_OFF)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .new_seg(flush_seg), .new_off(flush_off), .room(room),
      .seg_q(seg_q), .off_q(off_q), .push(push),
      .ale(bus_ale), .rd(bus_rd), .mio(bus_mio)
   );

   pfq_addr_gen #(
      .SEG_W(SEG_W), .OFF_W(OFF_W), .SHIFT(ADDR_SHIFT),
      .PA_W(PA_W), .SPLIT(SPLIT_ADDER)
   ) u_agen (
      .seg(seg_q), .off(off_q), .phys(bus_addr)
   );

   pfq_byte_fifo #(.DEPTH(DEPTH), .DW(DW)) u_fifo (
      .clk(clk), .rst_n(rst_n), .clr(flush),
      .push(push), .push_data(bus_data), .pop_req(pop),
      .head(q_byte), .valid(q_valid), .count(q_count), .free_after(room)
   );

   AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rd |-> $stable(bus_addr));                  // R1
   AST_MEM_SEL: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_ale || bus_rd) |-> bus_mio);               // R10
   AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({bus_ale, bus_rd}));                   // R3
endmodule

// File: tb/sim_pfq_prefetch_unit.sv
module sim_pfq_prefetch_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        flush = 1'b0;
   logic [15:0] flush_seg = '0;
   logic [15:0] flush_off = '0;
   logic        pop = 1'b0;
   logic [7:0]  q_byte;
   logic        q_valid;
   logic [2:0]  q_count;
   logic [19:0] bus_addr;
   logic        bus_ale, bus_rd, bus_mio;
   logic [7:0]  bus_data;

   int n_chk = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   function automatic logic [7:0] mem_byte(input logic [19:0] a);
      return a[7:0] ^ a[15:8] ^ {a[19:16], a[19:16]} ^ 8'h5A;
   endfunction

   function automatic logic [19:0] phys(input logic [15:0] s, input logic [15:0] o, input int k);
      logic [15:0] ok;
      ok = o + 16'(k);
      return 20'({s, 4'h0} + {4'h0, ok});
   endfunction

   assign bus_data = mem_byte(bus_addr);

   pfq_prefetch_unit u0 (
      .clk(clk), .rst_n(rst_n), .flush(flush), .flush_seg(flush_seg),
      .flush_off(flush_off), .pop(pop), .q_byte(q_byte), .q_valid(q_valid),
      .q_count(q_count), .bus_addr(bus_addr), .bus_ale(bus_ale),
      .bus_rd(bus_rd), .bus_mio(bus_mio), .bus_data(bus_data)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic do_flush(input logic [15:0] s, input logic [15:0] o);
      @(negedge clk);
      flush = 1'b1; flush_seg = s; flush_off = o;
      @(negedge clk);
      flush = 1'b0;
   endtask

   // wait until six bytes are queued, checking every address phase
   task automatic fill(input logic [15:0] s, input logic [15:0] o);
      int k = 0;
      for (int c = 0; c < 60 && q_count != 3'd6; c++) begin
         @(negedge clk);
         if (bus_ale) begin
            chk("R1 addr", 32'(bus_addr), 32'(phys(s, o, k)));
            chk("R10 mio", 32'(bus_mio), 32'd1);
            k++;
         end
      end
      chk("R5 full count", 32'(q_count), 32'd6);
   endtask

   localparam logic [31:0] VEC [5] = '{
      32'h0000_0000, 32'h1234_5678, 32'hFFFF_FFFE, 32'hF000_FFFD, 32'hABCD_00F0
   };

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [15:0] s, o;
      // R2 reset state
      repeat (3) @(negedge clk);
      chk("R2 count", 32'(q_count), 32'd0);
      chk("R2 valid", 32'(q_valid), 32'd0);
      chk("R2 ale", 32'(bus_ale), 32'd0);
      chk("R2 rd", 32'(bus_rd), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R2 first ale", 32'(bus_ale), 32'd1);
      chk("R2 first addr", 32'(bus_addr), 32'h000F_FFF0);

      // vector table walk: flush, fill, hold when full, drain in order
      foreach (VEC[i]) begin
         s = VEC[i][31:16];
         o = VEC[i][15:0];
         do_flush(s, o);
         chk("R9 flush empties", 32'(q_count), 32'd0);
         fill(s, o);
         for (int c = 0; c < 8; c++) begin
            @(negedge clk);
            chk("R5 no fetch when full", 32'(bus_ale), 32'd0);
         end
         for (int k = 0; k < 6; k++) begin
            chk("R6 valid", 32'(q_valid), 32'd1);
            chk("R4 R6 byte order", 32'(q_byte), 32'(mem_byte(phys(s, o, k))));
            pop = 1'b1;
            @(negedge clk);
            pop = 1'b0;
         end
      end

      // R3 strobe sequence and capture point
      do_flush(16'h2000, 16'h0010);
      @(negedge clk);
      chk("R3 c1 ale", 32'(bus_ale), 32'd1);
      chk("R3 c1 rd", 32'(bus_rd), 32'd0);
      chk("R3 c1 mio", 32'(bus_mio), 32'd1);
      @(negedge clk);
      chk("R3 c2 ale", 32'(bus_ale), 32'd0);
      chk("R3 c2 rd", 32'(bus_rd), 32'd1);
      @(negedge clk);
      chk("R3 c3 rd", 32'(bus_rd), 32'd1);
      chk("R3 c3 count", 32'(q_count), 32'd0);
      @(negedge clk);
      chk("R3 captured", 32'(q_count), 32'd1);
      chk("R3 byte", 32'(q_byte), 32'(mem_byte(20'h20010)));
      chk("R3 next ale", 32'(bus_ale), 32'd1);

      // R7 pop on empty
      do_flush(16'h0300, 16'h0004);
      pop = 1'b1;
      @(negedge clk);
      pop = 1'b0;
      chk("R7 count after empty pop", 32'(q_count), 32'd0);
      chk("R7 valid after empty pop", 32'(q_valid), 32'd0);
      repeat (3) @(negedge clk);
      chk("R7 count", 32'(q_count), 32'd1);
      chk("R7 head", 32'(q_byte), 32'(mem_byte(20'h03004)));

      // R8 pop and capture on the same edge
      do_flush(16'h4400, 16'h0100);
      for (int c = 0; c < 30 && q_count != 3'd2; c++) @(negedge clk);
      @(negedge clk);               // second read cycle
      @(negedge clk);               // third read cycle
      chk("R8 in last read", 32'(bus_rd), 32'd1);
      pop = 1'b1;
      @(negedge clk);
      pop = 1'b0;
      chk("R8 count held", 32'(q_count), 32'd2);
      chk("R8 head advanced", 32'(q_byte), 32'(mem_byte(20'h44101)));
      chk("R8 next fetch", 32'(bus_ale), 32'd1);
      pop = 1'b1;
      @(negedge clk);
      pop = 1'b0;
      chk("R8 tail byte", 32'(q_byte), 32'(mem_byte(20'h44102)));

      // R9 flush in the middle of a fetch
      do_flush(16'h1111, 16'h0000);
      for (int c = 0; c < 10 && !bus_ale; c++) @(negedge clk);
      @(negedge clk);
      chk("R9 mid-fetch rd", 32'(bus_rd), 32'd1);
      flush = 1'b1; flush_seg = 16'h7000; flush_off = 16'h0042;
      @(negedge clk);
      flush = 1'b0;
      chk("R9 aborted count", 32'(q_count), 32'd0);
      chk("R9 aborted rd", 32'(bus_rd), 32'd0);
      fill(16'h7000, 16'h0042);
      chk("R9 first byte new", 32'(q_byte), 32'(mem_byte(20'h70042)));

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule